// File: doc/BRIEF.md
# Power-Up Strap Latch and Clock-Group Mode Decoder

This block runs on the reference-crystal clock of a multi-output clock generator. After reset, a power-up timer runs. While it runs, a shared pin is held as an input and its level is latched as a frequency strap. When the timer expires, the pin becomes a driven reference-clock output and the strap value is frozen. The latched strap and two live select inputs are decoded into an operating mode. The mode is one of: three-state, test, three normal CPU-speed settings, or a reserved code.

For each of seven output groups the block gives an enable and a 3-bit frequency code for the synthesis logic. The groups are CPU, SDRAM, fixed 66 MHz, PCI, APIC, 48 MHz and REF. In test mode the crystal input carries an overdriven test clock, and the block builds every group's clock from it by fixed integer division. An active-low power-down input removes all group enables at once, without waiting for a clock edge. Enables change only while the related group clock is low, and all test dividers restart together, so no shortened pulse is emitted.

Top module: `clkgen_strap_mode`

## Requirements
- R1: The strap level is captured on every clock edge while the power-up timer runs, including the final edge. After that edge it no longer changes, whatever the strap pin does.
- R2: `pin_drive` is low in reset and for the first PWRUP_CYCLES clock edges after reset is released. It goes high after edge PWRUP_CYCLES unless the mode is three-state. `grp_en` is all zero in reset and until the mode has been decoded.
- R3: With select inputs sel_hi=0 and sel_lo=0, whatever the strap value, `hiz` is 1, `pin_drive` is 0, every enable is 0 and every frequency code is 0 (off).
- R4: With sel_hi=0 and sel_lo=1 (test mode), every group is enabled and every frequency code is 1 (test).
- R5: In test mode, a group's clock is the test clock divided by a fixed ratio with 50% duty. The ratios are: REF 1 (follows the clock), 48 MHz group 2, CPU 4, SDRAM 4, 66 MHz group 6, PCI 12, APIC 12.
- R6: The CPU frequency code depends on the strap and the selects. Strap 0 with sel=10 gives 4 (66 MHz). Strap 0 with sel=11 gives 5 (100 MHz). Strap 1 with sel=11 gives 6 (133 MHz).
- R7: In every normal mode, the other groups have fixed codes: SDRAM 5 (100), 66 MHz group 4, PCI 2 (33), APIC 2, 48 MHz group 3 (48), REF 7 (crystal). All enables are 1.
- R8: Strap 1 with sel=10 is reserved. `rsvd` is 1, all enables are 0 and all codes are 0. `pin_drive` stays 1.
- R9: While `pwr_dn_n` is low, `grp_en` and `grp_clk` are all zero at once, with no clock edge needed. The earlier enables come back when it is released.
- R10: After test mode is entered, all dividers leave reset together, so every divided group clock rises on the same edge whenever PCI's clock rises. Group bit order is CPU=0, SDRAM=1, 66 MHz=2, PCI=3, APIC=4, 48 MHz=5, REF=6. A group enable changes only on an edge where that group's divided clock was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference crystal clock (the test clock in test mode) |
| rst | input | 1 | Synchronous active-high reset |
| strap_in | input | 1 | Input level seen on the shared strap/reference pin |
| sel_hi | input | 1 | Upper function-select input |
| sel_lo | input | 1 | Lower function-select input |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down |
| pin_drive | output | 1 | 1 = shared pin drives the reference clock |
| strap_val | output | 1 | Latched strap level |
| hiz | output | 1 | Three-state mode active |
| rsvd | output | 1 | Reserved mode code selected |
| grp_en | output | 7 | Per-group output enable |
| grp_freq | output | 21 | Per-group 3-bit frequency code, group g at bits [3g+2:3g] |
| grp_clk | output | 7 | Per-group test-mode clock (zero outside test mode) |

## Verification
The hardest case to reach is a strap level that changes on the very last edge of the power-up window. The bench releases reset at a known edge and counts edges. It flips the strap just before the final timer edge, then flips it back after expiry, and checks that only the earlier change was kept. Divider phase is checked by sampling every group clock over a window whose length is a common multiple of all ratios. The bench counts rising samples and checks the coincidence of rises at each PCI rise.

// File: rtl/clkgen_mode_pkg.sv
package clkgen_mode_pkg;

    localparam int NUM_GROUPS = 7;
    localparam int FREQ_W     = 3;

    localparam int GRP_CPU   = 0;
    localparam int GRP_SDRAM = 1;
    localparam int GRP_66    = 2;
    localparam int GRP_PCI   = 3;
    localparam int GRP_APIC  = 4;
    localparam int GRP_48    = 5;
    localparam int GRP_REF   = 6;

    typedef enum logic [2:0] {
        MODE_OFF, MODE_HIZ, MODE_TEST, MODE_CPU66,
        MODE_CPU100, MODE_CPU133, MODE_RSVD
    } op_mode_e;

    typedef enum logic [FREQ_W-1:0] {
        FREQ_OFF  = 3'd0, FREQ_TEST = 3'd1, FREQ_33  = 3'd2, FREQ_48   = 3'd3,
        FREQ_66   = 3'd4, FREQ_100  = 3'd5, FREQ_133 = 3'd6, FREQ_XTAL = 3'd7
    } freq_code_e;

    function automatic op_mode_e decode_mode(logic strap, logic s_hi, logic s_lo);
        case ({s_hi, s_lo})
            2'b00:   return MODE_HIZ;
            2'b01:   return MODE_TEST;
            2'b10:   return strap ? MODE_RSVD : MODE_CPU66;
            default: return strap ? MODE_CPU133 : MODE_CPU100;
        endcase
    endfunction

    function automatic int test_ratio(int g);
        case (g)
            GRP_REF:                 return 1;
            GRP_48:                  return 2;
            GRP_66:                  return 6;
            GRP_PCI, GRP_APIC:       return 12;
            default:                 return 4;
        endcase
    endfunction

    function automatic logic mode_active(op_mode_e m);
        return (m == MODE_TEST) || (m == MODE_CPU66) ||
               (m == MODE_CPU100) || (m == MODE_CPU133);
    endfunction

    function automatic freq_code_e group_freq(op_mode_e m, int g);
        if (m == MODE_TEST) return FREQ_TEST;
        if (!mode_active(m)) return FREQ_OFF;
        case (g)
            GRP_CPU:  return (m == MODE_CPU66)  ? FREQ_66 :
                             (m == MODE_CPU100) ? FREQ_100 : FREQ_133;
            GRP_SDRAM:         return FREQ_100;
            GRP_66:            return FREQ_66;
            GRP_PCI, GRP_APIC: return FREQ_33;
            GRP_48:            return FREQ_48;
            default:           return FREQ_XTAL;
        endcase
    endfunction

endpackage

// File: rtl/pwrup_strap_timer.sv
module pwrup_strap_timer #(
    parameter int PWRUP_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst,
    input  logic strap_in,
    output logic timer_done,
    output logic strap_q
);
    localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PWRUP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            timer_done <= 1'b0;
            strap_q    <= 1'b0;
        end else if (!timer_done) begin
            cnt_q   <= cnt_q + 1'b1;
            strap_q <= strap_in;
            if (cnt_q == LAST) timer_done <= 1'b1;
        end
    end

    assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        timer_done |=> $stable(strap_q));
    assert_done_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        timer_done |=> timer_done);
endmodule

// File: rtl/test_clk_div.sv
module test_clk_div #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic clr,
    output logic div_q
);
    generate
        if (RATIO < 2) begin : g_pass
            assign div_q = 1'b0;
        end else begin : g_div
            localparam int HALF = RATIO / 2;
            localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
            localparam logic [CW-1:0] WRAP = CW'(HALF - 1);
            logic [CW-1:0] cnt_q;
            logic          out_q;
            always_ff @(posedge clk) begin
                if (clr) begin
                    cnt_q <= '0;
                    out_q <= 1'b0;
                end else begin
                    if (cnt_q == '0) out_q <= ~out_q;
                    cnt_q <= (cnt_q == WRAP) ? '0 : cnt_q + 1'b1;
                end
            end
            assign div_q = out_q;
        end
    endgenerate
endmodule

// File: rtl/group_en_gate.sv
module group_en_gate (
    input  logic clk,
    input  logic rst,
    input  logic want_en,
    input  logic clk_low,
    input  logic pwr_dn_n,
    output logic en_q,
    output logic en_out
);
    always_ff @(posedge clk) begin
        if (rst)          en_q <= 1'b0;
        else if (clk_low) en_q <= want_en;
    end

    assign en_out = en_q & pwr_dn_n;

    always_comb begin
        if (!pwr_dn_n) assert_pwrdn_off_R9: assert (en_out == 1'b0);
    end
endmodule

// File: rtl/clkgen_strap_mode.sv
module clkgen_strap_mode
    import clkgen_mode_pkg::*;
#(
    parameter int PWRUP_CYCLES = 28636
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         strap_in,
    input  logic                         sel_hi,
    input  logic                         sel_lo,
    input  logic                         pwr_dn_n,
    output logic                         pin_drive,
    output logic                         strap_val,
    output logic                         hiz,
    output logic                         rsvd,
    output logic [NUM_GROUPS-1:0]        grp_en,
    output logic [NUM_GROUPS*FREQ_W-1:0] grp_freq,
    output logic [NUM_GROUPS-1:0]        grp_clk
);
    logic     timer_done;
    logic     strap_q;
    op_mode_e mode_now;
    op_mode_e mode_q;
    logic     in_test;
    logic [NUM_GROUPS-1:0] div_q;
    logic [NUM_GROUPS-1:0] en_q;

    pwrup_strap_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .strap_in(strap_in),
        .timer_done(timer_done), .strap_q(strap_q)
    );

    assign mode_now = decode_mode(strap_q, sel_hi, sel_lo);

    always_ff @(posedge clk) begin
        if (rst)             mode_q <= MODE_OFF;
        else if (timer_done) mode_q <= mode_now;
        else                 mode_q <= MODE_OFF;
    end

    assign in_test   = (mode_q == MODE_TEST);
    assign pin_drive = timer_done && (mode_now != MODE_HIZ);
    assign strap_val = strap_q;
    assign hiz       = (mode_q == MODE_HIZ);
    assign rsvd      = (mode_q == MODE_RSVD);

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            test_clk_div #(.RATIO(test_ratio(g))) u_div (
                .clk(clk), .clr(rst || !in_test), .div_q(div_q[g])
            );
            group_en_gate u_gate (
                .clk(clk), .rst(rst), .want_en(mode_active(mode_q)),
                .clk_low(!div_q[g]), .pwr_dn_n(pwr_dn_n),
                .en_q(en_q[g]), .en_out(grp_en[g])
            );
            assign grp_freq[g*FREQ_W +: FREQ_W] = group_freq(mode_q, g);
            if (test_ratio(g) < 2) begin : g_ref
                assign grp_clk[g] = clk & in_test & grp_en[g];
            end else begin : g_divd
                assign grp_clk[g] = div_q[g] & grp_en[g];
            end

            assert_en_moves_low_R10: assert property (@(posedge clk) disable iff (rst)
                !$stable(en_q[g]) |-> !$past(div_q[g]));
        end
    endgenerate

    assert_pin_input_R2: assert property (@(posedge clk) disable iff (rst)
        !timer_done |-> !pin_drive);
    assert_hiz_off_R3: assert property (@(posedge clk) disable iff (rst)
        (hiz && $past(hiz)) |-> (en_q == '0 && !pin_drive));
    assert_rsvd_off_R8: assert property (@(posedge clk) disable iff (rst)
        (rsvd && $past(rsvd)) |-> (en_q == '0));
    assert_pwrdn_clk_R9: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |-> (grp_clk == '0));
endmodule

// File: tb/tb_clkgen_strap_mode.sv
module tb_clkgen_strap_mode;
    localparam int PW = 16;
    localparam int NG = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap_in = 1'b0, sel_hi = 1'b0, sel_lo = 1'b0, pwr_dn_n = 1'b1;
    logic pin_drive, strap_val, hiz, rsvd;
    logic [NG-1:0]   grp_en, grp_clk;
    logic [NG*3-1:0] grp_freq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    clkgen_strap_mode #(.PWRUP_CYCLES(PW)) dut (
        .clk(clk), .rst(rst), .strap_in(strap_in), .sel_hi(sel_hi), .sel_lo(sel_lo),
        .pwr_dn_n(pwr_dn_n), .pin_drive(pin_drive), .strap_val(strap_val), .hiz(hiz),
        .rsvd(rsvd), .grp_en(grp_en), .grp_freq(grp_freq), .grp_clk(grp_clk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edge_sample();
        @(posedge clk); #1;
    endtask

    function automatic int exp_freq(int g, bit st, bit sh, bit sl);
        if (!sh && !sl) return 0;
        if (!sh && sl)  return 1;
        if (sh && !sl && st) return 0;
        case (g)
            0: return (!sl) ? 4 : (st ? 6 : 5);
            1: return 5;
            2: return 4;
            3, 4: return 2;
            5: return 3;
            default: return 7;
        endcase
    endfunction

    task automatic start(input bit st, input bit sh, input bit sl);
        @(negedge clk);
        rst = 1'b1; strap_in = st; sel_hi = sh; sel_lo = sl; pwr_dn_n = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // Reset state (R2)
        repeat (3) @(negedge clk);
        chk("R2 reset pin_drive", pin_drive, 0);
        chk("R2 reset grp_en", grp_en, 0);
        chk("R8 reset rsvd", rsvd, 0);

        // R1/R2: timer length and last-edge strap capture
        start(0, 1, 1);
        for (int k = 1; k <= PW; k++) begin
            if (k == PW) begin
                chk("R2 pin input before expiry", pin_drive, 0);
                strap_in = 1'b1;
            end
            edge_sample();
        end
        chk("R2 pin drives after expiry", pin_drive, 1);
        chk("R1 strap latched on final edge", strap_val, 1);
        @(negedge clk); strap_in = 1'b0;
        repeat (5) edge_sample();
        chk("R1 strap frozen", strap_val, 1);
        chk("R1 cpu code keeps strap", grp_freq[2:0], 6);

        // Sweep all strap/select combinations (R3 R4 R6 R7 R8)
        for (int c = 0; c < 8; c++) begin
            bit st, sh, sl;
            st = c[2]; sh = c[1]; sl = c[0];
            start(st, sh, sl);
            repeat (PW + 4) edge_sample();
            chk("R3 hiz flag", hiz, (!sh && !sl));
            chk("R8 rsvd flag", rsvd, (sh && !sl && st));
            chk("R3 R8 pin_drive", pin_drive, !(!sh && !sl));
            chk("R4 R7 R8 enables", grp_en,
                ((!sh && !sl) || (sh && !sl && st)) ? 0 : 7'h7f);
            for (int g = 0; g < NG; g++)
                chk(g == 0 ? "R6 cpu code" : (sh ? "R7 group code" : "R4 R3 group code"),
                    grp_freq[g*3 +: 3], exp_freq(g, st, sh, sl));
        end

        // R5/R10: test-mode division
        begin
            int rises [NG];
            logic [NG-1:0] prev;
            int bad_phase;
            start(0, 0, 1);
            repeat (PW + 20) edge_sample();
            for (int g = 0; g < NG; g++) rises[g] = 0;
            prev = grp_clk;
            bad_phase = 0;
            for (int k = 0; k < 24; k++) begin
                edge_sample();
                for (int g = 0; g < 6; g++)
                    if (grp_clk[g] && !prev[g]) rises[g]++;
                if (grp_clk[3] && !prev[3] && (grp_clk[5:0] != 6'h3f)) bad_phase++;
                chk("R5 ref high phase", grp_clk[6], 1);
                prev = grp_clk;
            end
            @(negedge clk); #1;
            chk("R5 ref low phase", grp_clk[6], 0);
            chk("R5 cpu /4", rises[0], 6);
            chk("R5 sdram /4", rises[1], 6);
            chk("R5 66 /6", rises[2], 4);
            chk("R5 pci /12", rises[3], 2);
            chk("R5 apic /12", rises[4], 2);
            chk("R5 48 /2", rises[5], 12);
            chk("R10 dividers in phase", bad_phase, 0);

            // R9 in test mode
            @(negedge clk); pwr_dn_n = 1'b0;
            for (int k = 0; k < 13; k++) begin
                edge_sample();
                chk("R9 clocks stopped", grp_clk, 0);
            end
            @(negedge clk); pwr_dn_n = 1'b1;
        end

        // R9 in normal mode, async
        start(0, 1, 1);
        repeat (PW + 4) edge_sample();
        @(negedge clk); pwr_dn_n = 1'b0; #1;
        chk("R9 async disable", grp_en, 0);
        pwr_dn_n = 1'b1; #1;
        chk("R9 release restores", grp_en, 7'h7f);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule